// File: doc/BRIEF.md
# Write-Through Invalidate Snoop Controller

This block is the coherence controller of a small direct-mapped, write-through cache. Each line is either valid or invalid. The processor side issues one read or write at a time through a request/ready handshake. A read that hits is answered from local storage. A read that misses starts a bus read, and the returned word fills the line. Every write goes onto the bus as a bus write. A write never allocates a line, and on a hit it refreshes the local copy when the bus accepts the write.

The controller also watches a snoop port that reflects every transaction on a shared bus. A write made by another agent to an address this cache holds invalidates that line, so the next local read fetches the new value. Transactions that carry this controller's own requester ID are ignored on the snoop port, and so are snooped reads. The bus is atomic: one transaction completes before the next begins, and the processor waits for each operation to finish before it issues another.

Addresses are word addresses. The line index is the low log2(LINES) address bits and the tag is the remaining upper bits.

Top module: `wt_snoop_ctrl`

## Requirements
- R1: After reset every line is invalid, cpu_ready_o is 1, and bus_req_o and cpu_done_o are 0. The first read of any address therefore goes to the bus.
- R2: A read to an invalid line, or to a line whose tag differs, drives bus_req_o=1 with bus_we_o=0 and the request address. In the cycle after bus_ack_i, cpu_done_o pulses with cpu_rdata_o equal to the bus_rdata_i that came with the ack, and the line becomes valid.
- R3: A read to a valid line with a matching tag pulses cpu_done_o in the cycle after acceptance and returns the stored word. It raises no bus request.
- R4: Every accepted write drives bus_req_o=1 with bus_we_o=1, the write address and the write data from the cycle after acceptance until bus_ack_i. These values stay stable while bus_req_o is held. cpu_done_o pulses in the cycle after the ack.
- R5: A write whose address hits a valid line updates the stored word in the cycle the bus accepts the write. A later read of that address hits and returns the new word.
- R6: A write that misses leaves the line invalid (no allocation), so a later read of that address goes to the bus.
- R7: A snooped write (snp_valid_i=1, snp_we_i=1) whose snp_id_i differs from MY_ID and whose address matches a valid line makes that line invalid.
- R8: The snoop port has no effect on stored lines in three cases: a snooped transaction carrying MY_ID, a snooped read (snp_we_i=0), and a snooped write to the same index with a different tag.
- R9: While a bus transaction is outstanding, cpu_ready_o is 0. bus_req_o holds its value until bus_ack_i, for any number of wait cycles.
- R10: If an invalidating snoop and a processor read lookup of the same line fall in the same cycle, the invalidation wins and the read is handled as a miss on the bus.
- R11: The cache is direct-mapped. Filling a line with one tag evicts another address that shares its index, so a read of the evicted address misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_req_i | input | 1 | Processor request, taken when cpu_ready_o is 1 |
| cpu_we_i | input | 1 | 1 = write, 0 = read |
| cpu_addr_i | input | ADDR_W | Word address |
| cpu_wdata_i | input | DATA_W | Write data |
| cpu_ready_o | output | 1 | Controller can take a request |
| cpu_done_o | output | 1 | One-cycle completion pulse |
| cpu_rdata_o | output | DATA_W | Read data, valid with cpu_done_o on reads |
| bus_req_o | output | 1 | Bus transaction request, held until ack |
| bus_we_o | output | 1 | 1 = bus write, 0 = bus read |
| bus_addr_o | output | ADDR_W | Bus address |
| bus_wdata_o | output | DATA_W | Bus write data |
| bus_id_o | output | ID_W | Requester ID of this controller (MY_ID) |
| bus_ack_i | input | 1 | Bus transaction completes this cycle |
| bus_rdata_i | input | DATA_W | Bus read data, valid with bus_ack_i |
| snp_valid_i | input | 1 | Snooped bus transaction present |
| snp_we_i | input | 1 | Snooped transaction is a write |
| snp_addr_i | input | ADDR_W | Snooped word address |
| snp_id_i | input | ID_W | Requester ID of the snooped transaction |

## Verification
A processor read lookup and an invalidating snoop of the same line can occur in the same cycle. That is the case where a stale hit could slip through. The bench arranges it by presenting a read request for a line it knows to be valid, with a foreign-ID snooped write to that address on the same clock edge. It passes only if the read goes to the bus and returns the updated memory word. The same pairing with the snooped write carrying the controller's own ID must still hit with no bus request, which shows that only the foreign write turned the read into a miss.

// File: rtl/wts_pkg.sv
package wts_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_BUS_RD = 2'd1,
    ST_BUS_WR = 2'd2
  } wts_state_e;
endpackage

// File: rtl/wts_line_store.sv
module wts_line_store #(
  parameter  int LINES  = 16,
  parameter  int TAG_W  = 8,
  parameter  int DATA_W = 32,
  localparam int IDX_W  = $clog2(LINES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  // processor-side lookup port
  input  logic [IDX_W-1:0]  lk_idx_i,
  output logic              lk_valid_o,
  output logic [TAG_W-1:0]  lk_tag_o,
  output logic [DATA_W-1:0] lk_data_o,
  // snoop-side lookup port
  input  logic [IDX_W-1:0]  sp_idx_i,
  output logic              sp_valid_o,
  output logic [TAG_W-1:0]  sp_tag_o,
  // writes
  input  logic              fill_en_i,
  input  logic [IDX_W-1:0]  fill_idx_i,
  input  logic [TAG_W-1:0]  fill_tag_i,
  input  logic [DATA_W-1:0] fill_data_i,
  input  logic              upd_en_i,
  input  logic [IDX_W-1:0]  upd_idx_i,
  input  logic [DATA_W-1:0] upd_data_i,
  input  logic [LINES-1:0]  inv_i
);
  logic [LINES-1:0]  valid_w;
  logic [TAG_W-1:0]  tag_w  [LINES];
  logic [DATA_W-1:0] data_w [LINES];

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic              v_q;
    logic [TAG_W-1:0]  t_q;
    logic [DATA_W-1:0] d_q;
    logic              fill_here;
    logic              upd_here;

    assign fill_here = fill_en_i && (fill_idx_i == IDX_W'(g));
    assign upd_here  = upd_en_i  && (upd_idx_i  == IDX_W'(g));

    // invalidation beats a fill in the same cycle
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       v_q <= 1'b0;
      else if (inv_i[g]) v_q <= 1'b0;
      else if (fill_here) v_q <= 1'b1;
    end

    always_ff @(posedge clk_i) begin
      if (fill_here) begin
        t_q <= fill_tag_i;
        d_q <= fill_data_i;
      end else if (upd_here) begin
        d_q <= upd_data_i;
      end
    end

    assign valid_w[g] = v_q;
    assign tag_w[g]   = t_q;
    assign data_w[g]  = d_q;
  end

  assign lk_valid_o = valid_w[lk_idx_i];
  assign lk_tag_o   = tag_w[lk_idx_i];
  assign lk_data_o  = data_w[lk_idx_i];
  assign sp_valid_o = valid_w[sp_idx_i];
  assign sp_tag_o   = tag_w[sp_idx_i];
endmodule

// File: rtl/wts_snoop_match.sv
module wts_snoop_match #(
  parameter  int LINES  = 16,
  parameter  int ADDR_W = 12,
  parameter  int ID_W   = 2,
  parameter  int MY_ID  = 1,
  localparam int IDX_W  = $clog2(LINES),
  localparam int TAG_W  = ADDR_W - IDX_W
) (
  input  logic              snp_valid_i,
  input  logic              snp_we_i,
  input  logic [ADDR_W-1:0] snp_addr_i,
  input  logic [ID_W-1:0]   snp_id_i,
  output logic [IDX_W-1:0]  sp_idx_o,
  input  logic              sp_valid_i,
  input  logic [TAG_W-1:0]  sp_tag_i,
  output logic [LINES-1:0]  inv_o
);
  logic foreign_wr;
  logic line_hit;

  assign sp_idx_o   = snp_addr_i[IDX_W-1:0];
  assign foreign_wr = snp_valid_i && snp_we_i && (snp_id_i != ID_W'(MY_ID));
  assign line_hit   = foreign_wr && sp_valid_i && (sp_tag_i == snp_addr_i[ADDR_W-1:IDX_W]);

  for (genvar g = 0; g < LINES; g++) begin : g_dec
    assign inv_o[g] = line_hit && (sp_idx_o == IDX_W'(g));
  end
endmodule

// File: rtl/wts_ctrl_fsm.sv
module wts_ctrl_fsm
  import wts_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_req_i,
  input  logic              cpu_we_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  output logic              cpu_ready_o,
  output logic              cpu_done_o,
  output logic [DATA_W-1:0] cpu_rdata_o,
  output logic              bus_req_o,
  output logic              bus_we_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  input  logic              bus_ack_i,
  input  logic [DATA_W-1:0] bus_rdata_i,
  output logic [ADDR_W-1:0] lk_addr_o,
  input  logic              lk_hit_i,
  input  logic [DATA_W-1:0] lk_data_i,
  output logic              fill_en_o,
  output logic              upd_en_o
);
  wts_state_e        state_q, state_d;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;
  logic              done_q;
  logic              accept;

  assign cpu_ready_o = (state_q == ST_IDLE);
  assign accept      = cpu_ready_o && cpu_req_i;
  assign bus_req_o   = (state_q != ST_IDLE);
  assign bus_we_o    = (state_q == ST_BUS_WR);
  assign bus_addr_o  = addr_q;
  assign bus_wdata_o = wdata_q;
  assign cpu_done_o  = done_q;
  assign cpu_rdata_o = rdata_q;
  assign lk_addr_o   = cpu_ready_o ? cpu_addr_i : addr_q;
  assign fill_en_o   = (state_q == ST_BUS_RD) && bus_ack_i;
  assign upd_en_o    = (state_q == ST_BUS_WR) && bus_ack_i && lk_hit_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          if (cpu_we_i)       state_d = ST_BUS_WR;
          else if (!lk_hit_i) state_d = ST_BUS_RD;
        end
      end
      ST_BUS_RD, ST_BUS_WR: if (bus_ack_i) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= 1'b0;
      if (accept) begin
        addr_q  <= cpu_addr_i;
        wdata_q <= cpu_wdata_i;
        if (!cpu_we_i && lk_hit_i) begin
          done_q  <= 1'b1;
          rdata_q <= lk_data_i;
        end
      end
      if (state_q == ST_BUS_RD && bus_ack_i) begin
        done_q  <= 1'b1;
        rdata_q <= bus_rdata_i;
      end
      if (state_q == ST_BUS_WR && bus_ack_i) done_q <= 1'b1;
    end
  end
endmodule

// File: rtl/wt_snoop_ctrl.sv
module wt_snoop_ctrl #(
  parameter  int LINES  = 16,
  parameter  int ADDR_W = 12,
  parameter  int DATA_W = 32,
  parameter  int ID_W   = 2,
  parameter  int MY_ID  = 1,
  localparam int IDX_W  = $clog2(LINES),
  localparam int TAG_W  = ADDR_W - IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_req_i,
  input  logic              cpu_we_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  output logic              cpu_ready_o,
  output logic              cpu_done_o,
  output logic [DATA_W-1:0] cpu_rdata_o,
  output logic              bus_req_o,
  output logic              bus_we_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  output logic [ID_W-1:0]   bus_id_o,
  input  logic              bus_ack_i,
  input  logic [DATA_W-1:0] bus_rdata_i,
  input  logic              snp_valid_i,
  input  logic              snp_we_i,
  input  logic [ADDR_W-1:0] snp_addr_i,
  input  logic [ID_W-1:0]   snp_id_i
);
  logic [ADDR_W-1:0] lk_addr;
  logic [IDX_W-1:0]  lk_idx;
  logic [TAG_W-1:0]  lk_tag_req;
  logic              lk_valid;
  logic [TAG_W-1:0]  lk_tag;
  logic [DATA_W-1:0] lk_data;
  logic              lk_hit;
  logic [IDX_W-1:0]  sp_idx;
  logic              sp_valid;
  logic [TAG_W-1:0]  sp_tag;
  logic [LINES-1:0]  inv;
  logic              fill_en;
  logic              upd_en;

  assign bus_id_o   = ID_W'(MY_ID);
  assign lk_idx     = lk_addr[IDX_W-1:0];
  assign lk_tag_req = lk_addr[ADDR_W-1:IDX_W];
  // a same-cycle invalidation turns a would-be hit into a miss
  assign lk_hit     = lk_valid && (lk_tag == lk_tag_req) && !inv[lk_idx];

  wts_ctrl_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cpu_req_i   (cpu_req_i),
    .cpu_we_i    (cpu_we_i),
    .cpu_addr_i  (cpu_addr_i),
    .cpu_wdata_i (cpu_wdata_i),
    .cpu_ready_o (cpu_ready_o),
    .cpu_done_o  (cpu_done_o),
    .cpu_rdata_o (cpu_rdata_o),
    .bus_req_o   (bus_req_o),
    .bus_we_o    (bus_we_o),
    .bus_addr_o  (bus_addr_o),
    .bus_wdata_o (bus_wdata_o),
    .bus_ack_i   (bus_ack_i),
    .bus_rdata_i (bus_rdata_i),
    .lk_addr_o   (lk_addr),
    .lk_hit_i    (lk_hit),
    .lk_data_i   (lk_data),
    .fill_en_o   (fill_en),
    .upd_en_o    (upd_en)
  );

  wts_line_store #(.LINES(LINES), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .lk_idx_i    (lk_idx),
    .lk_valid_o  (lk_valid),
    .lk_tag_o    (lk_tag),
    .lk_data_o   (lk_data),
    .sp_idx_i    (sp_idx),
    .sp_valid_o  (sp_valid),
    .sp_tag_o    (sp_tag),
    .fill_en_i   (fill_en),
    .fill_idx_i  (lk_idx),
    .fill_tag_i  (lk_tag_req),
    .fill_data_i (bus_rdata_i),
    .upd_en_i    (upd_en),
    .upd_idx_i   (lk_idx),
    .upd_data_i  (bus_wdata_o),
    .inv_i       (inv)
  );

  wts_snoop_match #(.LINES(LINES), .ADDR_W(ADDR_W), .ID_W(ID_W), .MY_ID(MY_ID)) u_snoop (
    .snp_valid_i (snp_valid_i),
    .snp_we_i    (snp_we_i),
    .snp_addr_i  (snp_addr_i),
    .snp_id_i    (snp_id_i),
    .sp_idx_o    (sp_idx),
    .sp_valid_i  (sp_valid),
    .sp_tag_i    (sp_tag),
    .inv_o       (inv)
  );
endmodule

// File: rtl/wts_checker.sv
module wts_checker #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cpu_req_i,
  input logic              cpu_we_i,
  input logic [ADDR_W-1:0] cpu_addr_i,
  input logic [DATA_W-1:0] cpu_wdata_i,
  input logic              cpu_ready_o,
  input logic              cpu_done_o,
  input logic [DATA_W-1:0] cpu_rdata_o,
  input logic              bus_req_o,
  input logic              bus_we_o,
  input logic [ADDR_W-1:0] bus_addr_o,
  input logic [DATA_W-1:0] bus_wdata_o,
  input logic              bus_ack_i,
  input logic [DATA_W-1:0] bus_rdata_i
);
  assert_ready_low_on_bus_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o |-> !cpu_ready_o);

  assert_bus_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && !bus_ack_i |=> bus_req_o && $stable(bus_addr_o) && $stable(bus_we_o)
                                && $stable(bus_wdata_o));

  assert_write_to_bus_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_req_i && cpu_ready_o && cpu_we_i |=> bus_req_o && bus_we_o
      && bus_addr_o == $past(cpu_addr_i) && bus_wdata_o == $past(cpu_wdata_i));

  assert_fill_return_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && bus_ack_i && !bus_we_o |=> cpu_done_o && cpu_ready_o
      && cpu_rdata_o == $past(bus_rdata_i));

  assert_read_outcome_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_req_i && cpu_ready_o && !cpu_we_i |=> cpu_done_o || (bus_req_o && !bus_we_o));

  assert_done_has_cause_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_done_o |-> $past(cpu_req_i && cpu_ready_o) || $past(bus_req_o && bus_ack_i));
endmodule

bind wt_snoop_ctrl wts_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cpu_req_i   (cpu_req_i),
  .cpu_we_i    (cpu_we_i),
  .cpu_addr_i  (cpu_addr_i),
  .cpu_wdata_i (cpu_wdata_i),
  .cpu_ready_o (cpu_ready_o),
  .cpu_done_o  (cpu_done_o),
  .cpu_rdata_o (cpu_rdata_o),
  .bus_req_o   (bus_req_o),
  .bus_we_o    (bus_we_o),
  .bus_addr_o  (bus_addr_o),
  .bus_wdata_o (bus_wdata_o),
  .bus_ack_i   (bus_ack_i),
  .bus_rdata_i (bus_rdata_i)
);

// File: tb/sim_wt_snoop_ctrl.sv
`timescale 1ns/1ps
module sim_wt_snoop_ctrl;
  localparam int AW = 12, DW = 32, LN = 16, IDW = 2, MYID = 1;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic           cpu_req = 0, cpu_we = 0;
  logic [AW-1:0]  cpu_addr = '0;
  logic [DW-1:0]  cpu_wdata = '0;
  logic           cpu_ready_o, cpu_done_o;
  logic [DW-1:0]  cpu_rdata_o;
  logic           bus_req_o, bus_we_o;
  logic [AW-1:0]  bus_addr_o;
  logic [DW-1:0]  bus_wdata_o;
  logic [IDW-1:0] bus_id_o;
  logic           bus_ack = 0;
  logic [DW-1:0]  bus_rdata = '0;
  logic           snp_valid = 0, snp_we = 0;
  logic [AW-1:0]  snp_addr = '0;
  logic [IDW-1:0] snp_id = '0;

  wt_snoop_ctrl #(.LINES(LN), .ADDR_W(AW), .DATA_W(DW), .ID_W(IDW), .MY_ID(MYID)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .cpu_req_i(cpu_req), .cpu_we_i(cpu_we), .cpu_addr_i(cpu_addr), .cpu_wdata_i(cpu_wdata),
    .cpu_ready_o(cpu_ready_o), .cpu_done_o(cpu_done_o), .cpu_rdata_o(cpu_rdata_o),
    .bus_req_o(bus_req_o), .bus_we_o(bus_we_o), .bus_addr_o(bus_addr_o),
    .bus_wdata_o(bus_wdata_o), .bus_id_o(bus_id_o), .bus_ack_i(bus_ack), .bus_rdata_i(bus_rdata),
    .snp_valid_i(snp_valid), .snp_we_i(snp_we), .snp_addr_i(snp_addr), .snp_id_i(snp_id)
  );

  int checks = 0, errors = 0;
  logic [DW-1:0] mem [int];

  // results of the last access
  logic [DW-1:0] res_rd;
  bit            res_bus, res_bwe, stall_ok, rdy_at_req;
  logic [AW-1:0] res_baddr;
  logic [DW-1:0] res_bdata;

  function automatic logic [DW-1:0] mem_rd(input logic [AW-1:0] a);
    if (mem.exists(int'(a))) return mem[int'(a)];
    return {20'hC0DE0, a};
  endfunction

  task automatic chk(input string rq, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic access(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input int ack_dly, input bit sv, input logic [IDW-1:0] sid);
    @(negedge clk);
    rdy_at_req = cpu_ready_o;
    cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
    if (sv) begin
      snp_valid = 1; snp_we = 1; snp_id = sid; snp_addr = a;
      if (sid != IDW'(MYID)) mem[int'(a)] = mem_rd(a) ^ 32'h0000_FFFF;
    end
    @(posedge clk); #1;
    cpu_req = 0; snp_valid = 0;
    res_bus = 0; stall_ok = 1; res_rd = 'x;
    for (int n = 0; n < 100; n++) begin
      @(negedge clk);
      if (cpu_done_o) begin res_rd = cpu_rdata_o; break; end
      if (bus_req_o) begin
        res_bus = 1; res_bwe = bus_we_o; res_baddr = bus_addr_o; res_bdata = bus_wdata_o;
        if (cpu_ready_o) stall_ok = 0;
        for (int k = 0; k < ack_dly; k++) begin
          @(negedge clk);
          if (!bus_req_o || cpu_ready_o || bus_addr_o !== res_baddr || bus_we_o !== res_bwe) stall_ok = 0;
        end
        bus_ack = 1; bus_rdata = mem_rd(res_baddr);
        if (res_bwe) mem[int'(res_baddr)] = res_bdata;
        @(posedge clk); #1 bus_ack = 0;
      end
    end
  endtask

  task automatic snoop(input bit we, input logic [IDW-1:0] id, input logic [AW-1:0] a);
    @(negedge clk);
    snp_valid = 1; snp_we = we; snp_id = id; snp_addr = a;
    if (we && id != IDW'(MYID)) mem[int'(a)] = mem_rd(a) + 32'h100;
    @(posedge clk); #1 snp_valid = 0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1", "ready after reset", cpu_ready_o, 1);
    chk("R1", "bus_req after reset", bus_req_o, 0);
    chk("R1", "done after reset", cpu_done_o, 0);
    chk("R1", "bus id", bus_id_o, MYID);
  endtask

  task automatic t_read_miss_hit();
    logic [DW-1:0] e;
    e = mem_rd(12'h013);
    access(0, 12'h013, '0, 0, 0, '0);
    chk("R1", "first read uses bus", res_bus, 1);
    chk("R2", "miss bus is read", res_bwe, 0);
    chk("R2", "miss bus address", res_baddr, 12'h013);
    chk("R2", "miss data", res_rd, e);
    access(0, 12'h013, '0, 0, 0, '0);
    chk("R3", "hit without bus", res_bus, 0);
    chk("R3", "hit data", res_rd, e);
  endtask

  task automatic t_write_hit();
    access(1, 12'h013, 32'hA5A5_0001, 0, 0, '0);
    chk("R4", "write uses bus", res_bus, 1);
    chk("R4", "bus write flag", res_bwe, 1);
    chk("R4", "bus write addr", res_baddr, 12'h013);
    chk("R4", "bus write data", res_bdata, 32'hA5A5_0001);
    access(0, 12'h013, '0, 0, 0, '0);
    chk("R5", "read after write hit no bus", res_bus, 0);
    chk("R5", "updated local copy", res_rd, 32'hA5A5_0001);
  endtask

  task automatic t_write_miss();
    access(1, 12'h024, 32'h5A5A_0002, 0, 0, '0);
    chk("R4", "write miss uses bus", res_bwe, 1);
    access(0, 12'h024, '0, 0, 0, '0);
    chk("R6", "no allocate: read misses", res_bus, 1);
    chk("R6", "read returns memory", res_rd, 32'h5A5A_0002);
  endtask

  task automatic t_snoop_filter();
    snoop(1, IDW'(MYID), 12'h013);
    access(0, 12'h013, '0, 0, 0, '0);
    chk("R8", "own-id snoop ignored", res_bus, 0);
    snoop(0, 2'd2, 12'h013);
    access(0, 12'h013, '0, 0, 0, '0);
    chk("R8", "snooped read ignored", res_bus, 0);
    snoop(1, 2'd2, 12'h113);
    access(0, 12'h013, '0, 0, 0, '0);
    chk("R8", "other-tag snoop ignored", res_bus, 0);
    chk("R8", "data intact", res_rd, 32'hA5A5_0001);
  endtask

  task automatic t_snoop_inv();
    snoop(1, 2'd2, 12'h013);
    access(0, 12'h013, '0, 0, 0, '0);
    chk("R7", "foreign write invalidates", res_bus, 1);
    chk("R7", "refetch new value", res_rd, 32'hA5A5_0101);
  endtask

  task automatic t_conflict();
    access(0, 12'h035, '0, 0, 0, '0);
    access(0, 12'h135, '0, 0, 0, '0);
    chk("R11", "same-index other tag misses", res_bus, 1);
    access(0, 12'h135, '0, 0, 0, '0);
    chk("R11", "new tag now hits", res_bus, 0);
    access(0, 12'h035, '0, 0, 0, '0);
    chk("R11", "evicted tag misses", res_bus, 1);
  endtask

  task automatic t_stall();
    logic [DW-1:0] e;
    e = mem_rd(12'h04A);
    access(0, 12'h04A, '0, 4, 0, '0);
    chk("R9", "held request, ready low", stall_ok, 1);
    chk("R9", "data after wait", res_rd, e);
    access(1, 12'h04A, 32'h1234_5678, 3, 0, '0);
    chk("R9", "held write request", stall_ok, 1);
    access(0, 12'h04A, '0, 0, 0, '0);
    chk("R9", "ready for next request", rdy_at_req, 1);
    chk("R5", "hit after delayed write", res_rd, 32'h1234_5678);
  endtask

  task automatic t_same_cycle();
    logic [DW-1:0] e;
    access(0, 12'h024, '0, 0, 1, IDW'(MYID));
    chk("R10", "own-id same-cycle snoop keeps hit", res_bus, 0);
    access(0, 12'h024, '0, 0, 1, 2'd3);
    e = mem_rd(12'h024);
    chk("R10", "same-cycle invalidate forces miss", res_bus, 1);
    chk("R10", "fresh data", res_rd, e);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    t_reset();
    t_read_miss_hit();
    t_write_hit();
    t_write_miss();
    t_snoop_filter();
    t_snoop_inv();
    t_conflict();
    t_stall();
    t_same_cycle();
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule